// File: doc/BRIEF.md
# Maskable Calendar Alarm Matcher

This block watches the BCD time-of-day and calendar fields of a timekeeping counter and raises an alarm flag when they agree with a programmed alarm setting. There are two alarm units. The full unit compares seconds, minutes, hours, a day field, month and year. The reduced unit compares only minutes, hours and the day field, and it is evaluated only at the top of each minute. Each field has a "don't care" bit. The full unit's day field can be either the day of the month or the day of the week. Together these settings give repeating alarms that range from once per second up to yearly, as well as a one-time alarm.

The counter pulses `sec_tick` once per second, in the cycle after the time fields have settled. Comparison happens only on that pulse, so one matching second sets a flag once. The flags are sticky and are cleared by a status read pulse. Each flag has an enable bit. The active-low interrupt line is pulled low while any enabled flag is set, and the host detects the falling edge.

Top module: `cal_alarm_match`

## Requirements
- R1: While `rst_n` is low and after it is released, both bits of `alarm_flags` read 0 and `irq_n` reads 1 until a match occurs.
- R2: When all of its don't-care bits are 0, the full alarm sets `alarm_flags[0]` only if seconds, minutes, hours, the selected day field, month and year all equal their alarm values on a `sec_tick` cycle.
- R3: For the full alarm, a 1 in `a1_mask` removes a field from the comparison. The bits are assigned as follows: bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day field, bit 4 month, bit 5 year. With all six bits set, the flag sets on every tick.
- R4: Each alarm has a day select bit. When it is 0, the day field is compared against `now_mday`. When it is 1, it is compared against `now_wday`.
- R5: No flag is set in a cycle where `sec_tick` is 0, even if all fields match.
- R6: The reduced alarm compares minutes, hours and the day field. In `a2_mask`, bit 0 is minutes, bit 1 is hours and bit 2 is the day field. It sets `alarm_flags[1]` only on a tick where `now_sec` equals 8'h00.
- R7: Flags stay set until a cycle with `status_rd` high, which clears both flags. A match on a tick in that same cycle leaves its flag set.
- R8: `irq_n` is 0 exactly when `alarm_flags & irq_en` is nonzero, where `irq_en[0]` serves the full alarm and `irq_en[1]` the reduced one. The enable bits have no effect on the flags themselves.
- R9: A flag set by a tick in cycle N is visible on `alarm_flags` and `irq_n` after the clock edge that ends cycle N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse: time fields updated, evaluate alarms |
| status_rd | input | 1 | One-cycle pulse: status read, clears flags |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current day of week, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| a1_sec | input | 8 | Full alarm seconds |
| a1_min | input | 8 | Full alarm minutes |
| a1_hour | input | 8 | Full alarm hours |
| a1_day | input | 8 | Full alarm day field |
| a1_mon | input | 8 | Full alarm month |
| a1_year | input | 8 | Full alarm year |
| a1_mask | input | 6 | Full alarm don't-care bits |
| a1_wday_sel | input | 1 | Full alarm day select (1 = weekday) |
| a2_min | input | 8 | Reduced alarm minutes |
| a2_hour | input | 8 | Reduced alarm hours |
| a2_day | input | 8 | Reduced alarm day field |
| a2_mask | input | 3 | Reduced alarm don't-care bits |
| a2_wday_sel | input | 1 | Reduced alarm day select (1 = weekday) |
| irq_en | input | 2 | Interrupt enables per alarm |
| alarm_flags | output | 2 | Sticky alarm flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets the following corner cases.

- **Reduced alarm outside second 00.** A reduced-alarm match is applied while the seconds field is not 00. A design that dropped the top-of-minute gate would raise the flag sixty times per minute.
- **Matching fields without a tick.** All fields match but `sec_tick` is low. A design that evaluates continuously would set the flag early and set it more than once.
- **Read and match in the same cycle.** A status read coincides with a new match. A design that gives the clear priority would lose that alarm.
- **Day select.** The weekday and date values are set to disagree, so a swapped selector is exposed.
- **Enable bits.** A disabled enable must leave the flag untouched while keeping `irq_n` high. A design that gates the flag with the enable would lose the pending status.

Random don't-care patterns cover each mask bit position.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int BCD_W    = 8;
  localparam int A1_NF    = 6;
  localparam int A2_NF    = 3;
  localparam int N_ALARMS = 2;

  // a field passes when it is masked out or equals its alarm value
  function automatic logic field_pass(input logic [BCD_W-1:0] now_v,
                                      input logic [BCD_W-1:0] tgt_v,
                                      input logic dont_care);
    return dont_care | (now_v == tgt_v);
  endfunction

  // day field source: weekday when sel is set, else day of month
  function automatic logic [BCD_W-1:0] day_pick(input logic sel,
                                                input logic [BCD_W-1:0] wday,
                                                input logic [BCD_W-1:0] mday);
    return sel ? wday : mday;
  endfunction
endpackage

// File: rtl/alarm_fields_cmp.sv
module alarm_fields_cmp
  import cal_alarm_pkg::*;
#(
  parameter int NF = 6
) (
  input  logic [NF-1:0][BCD_W-1:0] now_f,
  input  logic [NF-1:0][BCD_W-1:0] tgt_f,
  input  logic [NF-1:0]            mask_f,
  input  logic                     gate,
  input  logic                     tick,
  output logic                     hit_evt
);
  logic [NF-1:0] pass_vec;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign pass_vec[g] = field_pass(now_f[g], tgt_f[g], mask_f[g]);
  end

  assign hit_evt = tick & gate & (&pass_vec);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit_evt | (flag_q & ~clr);
  end

  assert_set_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> flag_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit_evt) |=> !flag_q);
  assert_rise_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit_evt));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             status_rd,
  input  logic [BCD_W-1:0] now_sec,
  input  logic [BCD_W-1:0] now_min,
  input  logic [BCD_W-1:0] now_hour,
  input  logic [BCD_W-1:0] now_wday,
  input  logic [BCD_W-1:0] now_mday,
  input  logic [BCD_W-1:0] now_mon,
  input  logic [BCD_W-1:0] now_year,
  input  logic [BCD_W-1:0] a1_sec,
  input  logic [BCD_W-1:0] a1_min,
  input  logic [BCD_W-1:0] a1_hour,
  input  logic [BCD_W-1:0] a1_day,
  input  logic [BCD_W-1:0] a1_mon,
  input  logic [BCD_W-1:0] a1_year,
  input  logic [A1_NF-1:0] a1_mask,
  input  logic             a1_wday_sel,
  input  logic [BCD_W-1:0] a2_min,
  input  logic [BCD_W-1:0] a2_hour,
  input  logic [BCD_W-1:0] a2_day,
  input  logic [A2_NF-1:0] a2_mask,
  input  logic             a2_wday_sel,
  input  logic [N_ALARMS-1:0] irq_en,
  output logic [N_ALARMS-1:0] alarm_flags,
  output logic             irq_n
);
  logic [A1_NF-1:0][BCD_W-1:0] a1_now, a1_tgt;
  logic [A2_NF-1:0][BCD_W-1:0] a2_now, a2_tgt;
  logic [N_ALARMS-1:0]         hit_evt;
  logic                        top_of_minute;

  assign top_of_minute = (now_sec == '0);

  // field order is the mask bit order
  assign a1_now = {now_year, now_mon, day_pick(a1_wday_sel, now_wday, now_mday),
                   now_hour, now_min, now_sec};
  assign a1_tgt = {a1_year, a1_mon, a1_day, a1_hour, a1_min, a1_sec};
  assign a2_now = {day_pick(a2_wday_sel, now_wday, now_mday), now_hour, now_min};
  assign a2_tgt = {a2_day, a2_hour, a2_min};

  alarm_fields_cmp #(.NF(A1_NF)) u_cmp_full (
    .now_f(a1_now), .tgt_f(a1_tgt), .mask_f(a1_mask),
    .gate(1'b1), .tick(sec_tick), .hit_evt(hit_evt[0]));

  alarm_fields_cmp #(.NF(A2_NF)) u_cmp_reduced (
    .now_f(a2_now), .tgt_f(a2_tgt), .mask_f(a2_mask),
    .gate(top_of_minute), .tick(sec_tick), .hit_evt(hit_evt[1]));

  for (genvar k = 0; k < N_ALARMS; k++) begin : g_flag
    alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt[k]),
      .clr(status_rd), .flag_q(alarm_flags[k]));
  end

  assign irq_n = ~|(alarm_flags & irq_en);

  assert_quiet_without_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !status_rd) |=> $stable(alarm_flags));
  assert_reduced_on_minute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flags[1]) |-> ($past(now_sec) == '0));
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (alarm_flags != '0));
endmodule

// File: tb/cal_alarm_match_tb_top.sv
module cal_alarm_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, status_rd = 1'b0;
  logic [7:0] now_sec, now_min, now_hour, now_wday, now_mday, now_mon, now_year;
  logic [7:0] a1_sec, a1_min, a1_hour, a1_day, a1_mon, a1_year;
  logic [5:0] a1_mask;
  logic       a1_wday_sel;
  logic [7:0] a2_min, a2_hour, a2_day;
  logic [2:0] a2_mask;
  logic       a2_wday_sel;
  logic [1:0] irq_en;
  logic [1:0] alarm_flags;
  logic       irq_n;
  logic [1:0] exp_st = 2'b00;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_alarm_match dut_i (.*);

  function automatic logic [7:0] to_bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic logic a1_match();
    logic [7:0] nv [6];
    logic [7:0] tv [6];
    nv = '{now_sec, now_min, now_hour, (a1_wday_sel ? now_wday : now_mday), now_mon, now_year};
    tv = '{a1_sec, a1_min, a1_hour, a1_day, a1_mon, a1_year};
    for (int i = 0; i < 6; i++)
      if (!a1_mask[i] && nv[i] != tv[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic a2_match();
    if (now_sec != 8'h00) return 1'b0;
    if (!a2_mask[0] && now_min != a2_min) return 1'b0;
    if (!a2_mask[1] && now_hour != a2_hour) return 1'b0;
    if (!a2_mask[2] && (a2_wday_sel ? now_wday : now_mday) != a2_day) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, sample at the next negedge
  task automatic step(input logic tk, input logic rd, input string req);
    logic h1, h2;
    sec_tick = tk; status_rd = rd;
    h1 = tk && a1_match();
    h2 = tk && a2_match();
    @(posedge clk);
    exp_st[0] = h1 | (exp_st[0] & ~rd);
    exp_st[1] = h2 | (exp_st[1] & ~rd);
    @(negedge clk);
    sec_tick = 0; status_rd = 0;
    chk(req, {6'd0, alarm_flags}, {6'd0, exp_st});
    chk({req, " R8 irq"}, {7'd0, irq_n}, {7'd0, ~|(exp_st & irq_en)});
  endtask

  task automatic set_now_eq_targets();
    now_sec = a1_sec; now_min = a1_min; now_hour = a1_hour;
    now_mon = a1_mon; now_year = a1_year;
    now_mday = a1_day; now_wday = 8'h03;
  endtask

  function automatic logic [7:0] pick(input logic [7:0] tgt, input int lo, input int hi);
    return ($urandom % 4 != 0) ? tgt : to_bcd(lo + int'($urandom % (hi - lo + 1)));
  endfunction

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    a1_sec = 8'h30; a1_min = 8'h15; a1_hour = 8'h09; a1_day = 8'h21;
    a1_mon = 8'h06; a1_year = 8'h24; a1_mask = 6'b0; a1_wday_sel = 0;
    a2_min = 8'h15; a2_hour = 8'h09; a2_day = 8'h21; a2_mask = 3'b0; a2_wday_sel = 0;
    irq_en = 2'b11;
    set_now_eq_targets();
    now_sec = 8'h01;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 flags in reset", {6'd0, alarm_flags}, 8'h00);
    chk("R1 irq in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags after reset", {6'd0, alarm_flags}, 8'h00);

    // R5: full match, no tick
    now_sec = 8'h30;
    step(0, 0, "R5 no tick");
    // R2/R9: one-time match on tick
    step(1, 0, "R2 one-time match");
    // R7: sticky, then cleared by read
    step(0, 0, "R7 sticky");
    step(0, 1, "R7 read clears");
    // R2: year differs -> no match
    now_year = 8'h25;
    step(1, 0, "R2 year mismatch");
    // R3: year masked -> yearly
    a1_mask = 6'b100000;
    step(1, 0, "R3 yearly");
    step(0, 1, "R7 clear");
    // R4: weekday select, date disagrees
    a1_mask = 6'b110000; a1_wday_sel = 1; a1_day = 8'h03; now_mday = 8'h11;
    step(1, 0, "R4 weekday match");
    a1_wday_sel = 0;
    step(1, 1, "R7 read with coincident miss / R4 date select");
    // R7: read and match in same cycle keeps flag
    a1_mask = 6'b111111;
    step(1, 0, "R3 every second");
    step(1, 1, "R7 match wins over read");
    step(0, 1, "R7 clear");
    // R6: reduced alarm, fields match but seconds not 00
    a1_mask = 6'b0; now_year = 8'h99;
    now_min = 8'h15; now_hour = 8'h09; now_mday = 8'h21; now_sec = 8'h30;
    step(1, 0, "R6 not top of minute");
    now_sec = 8'h00;
    step(1, 0, "R6 top of minute match");
    // R8: enable cleared keeps flag, irq high
    irq_en = 2'b01;
    @(negedge clk);
    chk("R8 disabled irq", {7'd0, irq_n}, 8'h01);
    chk("R8 flag kept", {6'd0, alarm_flags}, 8'h02);
    step(0, 1, "R7 clear");
    irq_en = 2'b11;
    // R6: reduced weekday select
    a2_wday_sel = 1; a2_day = 8'h05; now_wday = 8'h05; now_mday = 8'h01;
    step(1, 0, "R6/R4 reduced weekday");
    step(0, 1, "R7 clear");

    // random phase (R2 R3 R4 R5 R6 R7 R8)
    for (int it = 0; it < 600; it++) begin
      if (it % 40 == 0) begin
        a1_sec = to_bcd($urandom % 60); a1_min = to_bcd($urandom % 60);
        a1_hour = to_bcd($urandom % 24); a1_mon = to_bcd(1 + $urandom % 12);
        a1_year = to_bcd($urandom % 100);
        a2_min = to_bcd($urandom % 60); a2_hour = to_bcd($urandom % 24);
      end
      a1_mask = 6'($urandom); a1_wday_sel = 1'($urandom);
      a2_mask = 3'($urandom); a2_wday_sel = 1'($urandom);
      a1_day = a1_wday_sel ? to_bcd(1 + $urandom % 7) : to_bcd(1 + $urandom % 28);
      a2_day = a2_wday_sel ? to_bcd(1 + $urandom % 7) : to_bcd(1 + $urandom % 28);
      irq_en = 2'($urandom);
      now_sec  = ($urandom % 2 == 0) ? 8'h00 : pick(a1_sec, 0, 59);
      now_min  = pick(($urandom % 2 == 0) ? a1_min : a2_min, 0, 59);
      now_hour = pick(($urandom % 2 == 0) ? a1_hour : a2_hour, 0, 23);
      now_wday = pick(a1_wday_sel ? a1_day : a2_day, 1, 7);
      now_mday = pick(a1_wday_sel ? a2_day : a1_day, 1, 28);
      now_mon  = pick(a1_mon, 1, 12);
      now_year = pick(a1_year, 0, 99);
      step(($urandom % 4) != 0, ($urandom % 4) == 0, "R2-random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule